// File: doc/BRIEF.md
# Exception Vector and Status Control

This block keeps a processor's status control bits and, from them and from the current exception context, produces the 64-bit address execution must jump to, a take-exception signal and an interrupt-accepted signal. The status bits are a boot-vector select, two expanded-addressing enables (one for supervisor mode and one for user mode), a reverse-endian bit that is held at zero, a cache-check bit that has no effect, a parity-exception disable and a global interrupt enable.

Software updates the bits through a one-cycle write strobe and reads them back on `stat_o`. Reset and NMI both force the boot-vector select to 1, so vectors move into the boot region. All three outputs are combinational from the registered bits and the present inputs. The new bit values appear one clock edge after a write.

Top module: `exc_vec_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, `stat_o` reads 7'b100_0000: the boot select bit is 1 and every other bit is 0.
- R2: When `nmi_i` is high at a clock edge, the boot select bit (bit 6) becomes 1 at that edge. The other bits keep their values, and a write strobed in the same cycle is discarded.
- R3: When `wr_en_i` is high and `nmi_i` is low at a clock edge, `stat_o` takes `wr_data_i` at that edge, with bit 3 (reverse endian) always forced to 0. Bit layout: 6 boot select, 5 supervisor expanded, 4 user expanded, 3 reverse endian, 2 cache check, 1 parity disable, 0 interrupt enable.
- R4: With boot select 0 the ordinary TLB-miss vector is 0xFFFF_FFFF_8000_0000 and the general vector is 0xFFFF_FFFF_8000_0180. With boot select 1 these are 0xFFFF_FFFF_BFC0_0200 and 0xFFFF_FFFF_BFC0_0380.
- R5: A TLB miss (`exc_kind_i`=0) uses base+0x080 only in supervisor mode (`mode_i`=1) with bit 5 set, or in user mode (`mode_i`=2) with bit 4 set. Kernel mode (0) and code 3 always use the ordinary TLB-miss vector.
- R6: A cache parity error (`exc_kind_i`=1) raises no exception while bit 1 is set. Exceptions of kind 0 and 2 are raised whenever `exc_req_i` is high.
- R7: `irq_accept_o` is high when `irq_i` is high and bit 0 is set, or whenever `nmi_i` is high, whatever the value of bit 0.
- R8: `take_exc_o` is high when a raised exception or an accepted interrupt is present. `vec_addr_o` shows the TLB-miss vector only for a raised TLB-miss exception, and shows the general vector otherwise.
- R9: Bit 2 (cache check) is stored and read back but has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt strobe |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 7 | Status write data |
| stat_o | output | 7 | Current status bits |
| mode_i | input | 2 | Privilege mode: 0 kernel, 1 supervisor, 2 user |
| exc_req_i | input | 1 | Exception request |
| exc_kind_i | input | 2 | 0 TLB miss, 1 cache parity, 2/3 other |
| irq_i | input | 1 | Maskable interrupt request |
| vec_addr_o | output | 64 | Exception vector address |
| take_exc_o | output | 1 | Exception or interrupt is taken |
| irq_accept_o | output | 1 | Interrupt accepted |

## Verification
Two events can land in the same cycle: an NMI and a software status write. The NMI must win and discard the write. The bench drives both at once with write data that would clear the boot select bit and change the other bits, then checks that only the boot select bit changed. An NMI that coincides with a cleared interrupt enable is also provoked, both in directed steps and in the random mix, and is judged on `irq_accept_o` and `take_exc_o` in that same cycle.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int STAT_W = 7;

  typedef struct packed {
    logic bev;
    logic sx;
    logic ux;
    logic re;
    logic ce;
    logic de;
    logic ie;
  } stat_t;

  localparam stat_t STAT_RESET = stat_t'(7'b100_0000);

  localparam logic [1:0] MODE_KERNEL = 2'd0;
  localparam logic [1:0] MODE_SUPER  = 2'd1;
  localparam logic [1:0] MODE_USER   = 2'd2;

  localparam logic [1:0] KIND_TLB    = 2'd0;
  localparam logic [1:0] KIND_PARITY = 2'd1;
endpackage

// File: rtl/exc_stat_regs.sv
module exc_stat_regs
  import exc_vec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nmi_i,
  input  logic  wr_en_i,
  input  stat_t wr_data_i,
  output stat_t stat_q
);
  stat_t stat_d;
  logic  ld_en;

  assign ld_en = nmi_i | wr_en_i;

  always_comb begin
    stat_d = stat_q;
    if (nmi_i) begin
      stat_d.bev = 1'b1;
    end else if (wr_en_i) begin
      stat_d    = wr_data_i;
      stat_d.re = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
    end else if (ld_en) begin
      stat_q <= stat_d;
    end
  end

  // R2
  bev_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> (stat_q.bev && stat_q.ie == $past(stat_q.ie) && stat_q.sx == $past(stat_q.sx)));

  // R3
  write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !nmi_i) |=> (stat_q.ie == $past(wr_data_i.ie) && !stat_q.re));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !nmi_i) |=> $stable(stat_q));
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
  import exc_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ie_i,
  input  logic       de_i,
  input  logic       exc_req_i,
  input  logic [1:0] exc_kind_i,
  input  logic       irq_i,
  input  logic       nmi_i,
  output logic       irq_accept_o,
  output logic       take_exc_o,
  output logic       tlb_sel_o
);
  logic parity_blocked;
  logic raise_exc;

  always_comb begin
    parity_blocked = (exc_kind_i == KIND_PARITY) & de_i;
    raise_exc      = exc_req_i & ~parity_blocked;
    irq_accept_o   = (irq_i & ie_i) | nmi_i;
    take_exc_o     = raise_exc | irq_accept_o;
    tlb_sel_o      = raise_exc & (exc_kind_i == KIND_TLB);
  end

  // R7
  ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept_o && !nmi_i) |-> ie_i);

  // R7
  nmi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |-> (irq_accept_o && take_exc_o));

  // R6
  parity_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_kind_i == KIND_PARITY && de_i && !irq_accept_o) |-> !take_exc_o);
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_vec_pkg::*;
#(
  parameter int              ADDR_W    = 64,
  parameter int              OFS_W     = 12,
  parameter logic [ADDR_W-1:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [OFS_W-1:0]  XTLB_OFS  = 12'h080,
  parameter logic [OFS_W-1:0]  GEN_OFS   = 12'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bev_i,
  input  logic              sx_i,
  input  logic              ux_i,
  input  logic [1:0]        mode_i,
  input  logic              tlb_sel_i,
  output logic [ADDR_W-1:0] vec_o
);
  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  ofs;
  logic              use_xtlb;

  always_comb begin
    use_xtlb = ((mode_i == MODE_SUPER) & sx_i) | ((mode_i == MODE_USER) & ux_i);
    base     = bev_i ? BOOT_BASE : NORM_BASE;
    if (tlb_sel_i) ofs = use_xtlb ? XTLB_OFS : '0;
    else           ofs = GEN_OFS;
    vec_o    = base + ADDR_W'(ofs);
  end

  // R4
  boot_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bev_i |-> (vec_o[31:20] == 12'hBFC));

  // R5
  kernel_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_sel_i && mode_i == MODE_KERNEL) |-> (vec_o[7:0] == 8'h00));
endmodule

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic [1:0]        mode_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              take_exc_o,
  output logic              irq_accept_o
);
  stat_t stat_q;
  logic  tlb_sel;

  exc_stat_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_i     (nmi_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (stat_t'(wr_data_i)),
    .stat_q    (stat_q)
  );

  exc_irq_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .ie_i         (stat_q.ie),
    .de_i         (stat_q.de),
    .exc_req_i    (exc_req_i),
    .exc_kind_i   (exc_kind_i),
    .irq_i        (irq_i),
    .nmi_i        (nmi_i),
    .irq_accept_o (irq_accept_o),
    .take_exc_o   (take_exc_o),
    .tlb_sel_o    (tlb_sel)
  );

  exc_vec_sel #(.ADDR_W(ADDR_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bev_i     (stat_q.bev),
    .sx_i      (stat_q.sx),
    .ux_i      (stat_q.ux),
    .mode_i    (mode_i),
    .tlb_sel_i (tlb_sel),
    .vec_o     (vec_addr_o)
  );

  assign stat_o = stat_q;
endmodule

// File: tb/exc_vec_ctrl_test.sv
module exc_vec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_i, wr_en_i, exc_req_i, irq_i;
  logic [6:0]  wr_data_i, stat_o;
  logic [1:0]  mode_i, exc_kind_i;
  logic [63:0] vec_addr_o;
  logic        take_exc_o, irq_accept_o;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [6:0] m_stat;

  always #5 clk = ~clk;

  exc_vec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .stat_o(stat_o), .mode_i(mode_i),
    .exc_req_i(exc_req_i), .exc_kind_i(exc_kind_i), .irq_i(irq_i),
    .vec_addr_o(vec_addr_o), .take_exc_o(take_exc_o), .irq_accept_o(irq_accept_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic raise_ref(input logic [6:0] s);
    return exc_req_i && !(exc_kind_i == 2'd1 && s[1]);
  endfunction

  function automatic logic [63:0] vec_ref(input logic [6:0] s);
    logic [63:0] base;
    logic        xt;
    base = s[6] ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
    xt   = (mode_i == 2'd1 && s[5]) || (mode_i == 2'd2 && s[4]);
    if (raise_ref(s) && exc_kind_i == 2'd0) return base + (xt ? 64'h80 : 64'h0);
    return base + 64'h180;
  endfunction

  task automatic check_outs(input string tag);
    logic acc;
    acc = (irq_i && m_stat[0]) || nmi_i;
    chk({tag, " R7 irq_accept"}, {63'd0, irq_accept_o}, {63'd0, acc});
    chk({tag, " R6 R8 take_exc"}, {63'd0, take_exc_o}, {63'd0, raise_ref(m_stat) || acc});
    chk({tag, " R4 R5 R9 vec"}, vec_addr_o, vec_ref(m_stat));
  endtask

  // One clock: drive at falling edge, check combinational outputs, then update model.
  task automatic step(input logic nmi, input logic wr, input logic [6:0] d);
    @(negedge clk);
    nmi_i = nmi; wr_en_i = wr; wr_data_i = d;
    #1 check_outs("step");
    @(posedge clk);
    if (nmi)     m_stat[6] = 1'b1;
    else if (wr) m_stat = d & 7'b111_0111;
    @(negedge clk);
    nmi_i = 1'b0; wr_en_i = 1'b0;
    #1 chk("R2 R3 stat", {57'd0, stat_o}, {57'd0, m_stat});
  endtask

  task automatic set_ctx(input logic [1:0] md, input logic ex, input logic [1:0] k, input logic irq);
    @(negedge clk);
    mode_i = md; exc_req_i = ex; exc_kind_i = k; irq_i = irq;
    #1 check_outs("ctx");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; nmi_i = 0; wr_en_i = 0; wr_data_i = '0;
    mode_i = 0; exc_req_i = 0; exc_kind_i = 0; irq_i = 0;
    m_stat = 7'b100_0000;
    #23;
    // R1 reset value
    chk("R1 reset stat", {57'd0, stat_o}, 64'h40);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 stat after release", {57'd0, stat_o}, 64'h40);

    // R3 write with RE set: RE stays 0, CE stored
    step(1'b0, 1'b1, 7'b011_1111);
    // R7 IE set, irq accepted; then clear IE
    set_ctx(2'd0, 1'b0, 2'd2, 1'b1);
    step(1'b0, 1'b1, 7'b000_0110);
    set_ctx(2'd0, 1'b0, 2'd2, 1'b1);
    // R7 NMI overrides cleared IE; R2 NMI beats write in same cycle
    step(1'b1, 1'b1, 7'b011_1001);
    chk("R2 nmi discards write", {57'd0, stat_o}, 64'h46);
    // R6 parity masked by DE
    set_ctx(2'd1, 1'b1, 2'd1, 1'b0);
    chk("R6 parity masked", {63'd0, take_exc_o}, 64'd0);
    // R5 kernel TLB miss ordinary even with SX/UX set
    step(1'b0, 1'b1, 7'b011_0000);
    set_ctx(2'd0, 1'b1, 2'd0, 1'b0);
    chk("R5 kernel tlb", vec_addr_o, 64'hFFFF_FFFF_8000_0000);
    set_ctx(2'd2, 1'b1, 2'd0, 1'b0);
    chk("R5 user xtlb", vec_addr_o, 64'hFFFF_FFFF_8000_0080);
    set_ctx(2'd3, 1'b1, 2'd0, 1'b0);
    chk("R5 mode3 tlb", vec_addr_o, 64'hFFFF_FFFF_8000_0000);
    step(1'b1, 1'b0, 7'd0);
    set_ctx(2'd1, 1'b1, 2'd0, 1'b0);
    chk("R4 R5 boot xtlb", vec_addr_o, 64'hFFFF_FFFF_BFC0_0280);
    set_ctx(2'd1, 1'b1, 2'd2, 1'b0);
    chk("R4 boot general", vec_addr_o, 64'hFFFF_FFFF_BFC0_0380);

    // Full sweep of bev/sx/ux/de against reference
    for (int s = 0; s < 32; s++) begin
      step(1'b0, 1'b1, {s[4], s[3], s[2], 1'b0, 1'b0, s[1], s[0]});
      for (int c = 0; c < 64; c++)
        set_ctx(c[1:0], c[2], c[4:3], c[5]);
    end

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)      step(1'b1, r[4], r[11:5]);
      else if (r[3:0] < 4'd5)  step(1'b0, 1'b1, r[11:5]);
      else if (r[3:0] == 4'd5) step(1'b1, 1'b0, r[11:5]);
      else                     set_ctx(r[13:12], r[14], r[16:15], r[17]);
      if (r[20]) begin
        @(negedge clk);
        mode_i = r[22:21]; exc_req_i = r[23]; exc_kind_i = r[25:24]; irq_i = r[26];
        #1 check_outs("rand");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule